// File: doc/BRIEF.md
# Register Rename Unit with Tag-Indexed Data File

This block turns the architectural register numbers of a small group of instructions into physical register tags. A mapping table holds one entry for each architectural register, and that entry is the physical tag currently standing for the register. For each instruction in the group the block reads the table once for every source operand and once for the destination. The destination read gives the tag being replaced. Each instruction that writes a destination receives a fresh tag from a pool of free tags. The table is updated at the next clock edge.

Operand values are kept in one shared data array, with one word for each physical tag. At issue, the caller presents source tags on the read ports and gets the stored words back in the same cycle. A result is written at writeback under its tag. A release port returns a finished tag to the pool. The tag field is wider than the number of physical registers needs, so some tag codes exist that belong to no register. The allocator never hands these codes out, and reads and writes that use them have no effect on any register.

Slot 0 of a rename group is the oldest instruction. A source or destination in a younger slot takes the newly allocated tag of the nearest older slot in the same group that writes the same architectural register.

Top module: `rename_unit`

## Requirements
- R1: After reset, architectural register i maps to tag i for every i below NUM_ARCH. Tags NUM_ARCH to NUM_PHYS-1 are free, and all other tags are not.
- R2: A source tag output equals the table entry of its architectural register when no older slot in the group writes that register.
- R3: With ren_req high and no stall, each slot with ren_dst_en high receives a free tag. Tags go out lowest-numbered first, in slot order. The table takes the new tags at the next clock edge, and those tags stay out of the pool until they are released.
- R4: No tag equal to or above NUM_PHYS is ever allocated.
- R5: When ren_req is high and the pool holds fewer tags than the number of enabled destinations, ren_stall is high in that cycle. No table entry changes and no tag leaves the pool.
- R6: A source whose architectural register is written by an older slot in the same group takes the new tag of the nearest such older slot.
- R7: ren_old_tag gives the tag the destination register held before the slot, taking the nearest older same-group writer into account. When two slots write the same register, the younger slot's tag ends up in the table.
- R8: A release with rel_valid high and a tag below NUM_PHYS makes the tag allocatable from the next cycle. A release with a tag at or above NUM_PHYS is ignored.
- R9: A writeback with wb_valid high stores wb_data under wb_tag. From the next cycle on, every read port presenting that tag returns the word.
- R10: A read port presenting a tag at or above NUM_PHYS returns zero. A writeback to such a tag changes no stored word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ren_req | input | 1 | A rename group is presented this cycle |
| ren_dst_en | input | GROUP | Per slot: the instruction writes a destination |
| ren_src_arch | input | GROUP*NSRC*AREG_W | Source architectural register numbers |
| ren_dst_arch | input | GROUP*AREG_W | Destination architectural register numbers |
| ren_stall | output | 1 | Not enough free tags, so the group is not renamed |
| ren_src_tag | output | GROUP*NSRC*TAG_W | Physical tags for the sources |
| ren_dst_tag | output | GROUP*TAG_W | Newly allocated destination tags |
| ren_old_tag | output | GROUP*TAG_W | Tag the destination register held before this slot |
| rel_valid | input | 1 | Release a tag to the pool |
| rel_tag | input | TAG_W | Tag being released |
| wb_valid | input | 1 | Write a result to the data array |
| wb_tag | input | TAG_W | Tag written at writeback |
| wb_data | input | DATA_W | Result value |
| rd_tag | input | NRD*TAG_W | Issue read tags |
| rd_data | output | NRD*DATA_W | Values read for the issue tags |

## Verification
The bench builds the block with its default parameters: 32 architectural registers, 80 physical registers with 7-bit tags, a group of two instructions with two sources each, four read ports and 32-bit data. With 48 spare tags and up to two allocations per cycle, the pool runs dry after about two dozen unreleased renames. This makes the stall path and the refill by release easy to reach. The 7-bit tag leaves 48 codes that belong to no register, and random tags for reads, writebacks and releases land on these codes often. A group of two with a 32-entry register space makes same-register hazards inside a group frequent enough to exercise the bypass.

// File: rtl/rename_pkg.sv
package rename_pkg;
  localparam int DEF_NUM_ARCH = 32;
  localparam int DEF_NUM_PHYS = 80;
  localparam int DEF_GROUP    = 2;
  localparam int DEF_NSRC     = 2;
  localparam int DEF_NRD      = 4;
  localparam int DEF_DATA_W   = 32;

  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/rename_free_pool.sv
module rename_free_pool #(
  parameter int NUM_ARCH = 32,
  parameter int NUM_PHYS = 80,
  parameter int GROUP    = 2,
  parameter int TAG_W    = 7
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [GROUP-1:0]            take,
  input  logic                        rel_valid,
  input  logic [TAG_W-1:0]            rel_tag,
  output logic [GROUP-1:0]            grant_ok,
  output logic [GROUP-1:0][TAG_W-1:0] grant_tag
);
  logic [NUM_PHYS-1:0] free_q, free_d, avail;

  always_comb begin
    avail     = free_q;
    grant_ok  = '0;
    grant_tag = '0;
    for (int k = 0; k < GROUP; k++) begin
      for (int t = NUM_PHYS - 1; t >= 0; t--) begin
        if (avail[t]) begin
          grant_ok[k]  = 1'b1;
          grant_tag[k] = TAG_W'(t);
        end
      end
      if (grant_ok[k]) avail[grant_tag[k]] = 1'b0;
    end
  end

  always_comb begin
    free_d = free_q;
    for (int k = 0; k < GROUP; k++)
      if (take[k] && grant_ok[k]) free_d[grant_tag[k]] = 1'b0;
    if (rel_valid && (int'(rel_tag) < NUM_PHYS)) free_d[rel_tag] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int t = 0; t < NUM_PHYS; t++) free_q[t] <= (t >= NUM_ARCH);
    end else begin
      free_q <= free_d;
    end
  end

  for (genvar k = 0; k < GROUP; k++) begin : g_chk
    assert_grant_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
      grant_ok[k] |-> (int'(grant_tag[k]) < NUM_PHYS));
    assert_grant_was_free_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (take[k] && grant_ok[k]) |=> !free_q[$past(grant_tag[k])]);
  end
  assert_pool_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(free_q) <= NUM_PHYS - NUM_ARCH);
  assert_idle_pool_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (take == '0 && !rel_valid) |=> $stable(free_q));
endmodule

// File: rtl/rename_map_table.sv
module rename_map_table #(
  parameter int NUM_ARCH = 32,
  parameter int GROUP    = 2,
  parameter int NSRC     = 2,
  parameter int AREG_W   = 5,
  parameter int TAG_W    = 7
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic [GROUP-1:0][NSRC-1:0][AREG_W-1:0] src_arch,
  output logic [GROUP-1:0][NSRC-1:0][TAG_W-1:0]  src_tag,
  input  logic [GROUP-1:0][AREG_W-1:0]           dst_arch,
  output logic [GROUP-1:0][TAG_W-1:0]            old_tag,
  input  logic [GROUP-1:0]                       wr_en,
  input  logic [GROUP-1:0][TAG_W-1:0]            wr_tag
);
  logic [NUM_ARCH-1:0][TAG_W-1:0] map_q, map_d;

  always_comb begin
    for (int j = 0; j < GROUP; j++) begin
      old_tag[j] = map_q[dst_arch[j]];
      for (int s = 0; s < NSRC; s++) src_tag[j][s] = map_q[src_arch[j][s]];
    end
  end

  always_comb begin
    map_d = map_q;
    for (int j = 0; j < GROUP; j++)
      if (wr_en[j]) map_d[dst_arch[j]] = wr_tag[j];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_ARCH; i++) map_q[i] <= TAG_W'(i);
    end else begin
      map_q <= map_d;
    end
  end

  assert_map_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en == '0) |=> $stable(map_q));
endmodule

// File: rtl/rename_phys_file.sv
module rename_phys_file #(
  parameter int NUM_PHYS = 80,
  parameter int NRD      = 4,
  parameter int TAG_W    = 7,
  parameter int DATA_W   = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wb_valid,
  input  logic [TAG_W-1:0]             wb_tag,
  input  logic [DATA_W-1:0]            wb_data,
  input  logic [NRD-1:0][TAG_W-1:0]    rd_tag,
  output logic [NRD-1:0][DATA_W-1:0]   rd_data
);
  logic [NUM_PHYS-1:0][DATA_W-1:0] regs_q;
  logic                            wr_hit;

  assign wr_hit = wb_valid && (int'(wb_tag) < NUM_PHYS);

  always_ff @(posedge clk) begin
    if (wr_hit) regs_q[wb_tag] <= wb_data;
  end

  always_comb begin
    for (int r = 0; r < NRD; r++)
      rd_data[r] = (int'(rd_tag[r]) < NUM_PHYS) ? regs_q[rd_tag[r]] : '0;
  end

  for (genvar r = 0; r < NRD; r++) begin : g_chk
    assert_read_after_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hit && rd_tag[r] == wb_tag) |=> (rd_tag[r] != $past(wb_tag)) || (rd_data[r] == $past(wb_data)));
  end
endmodule

// File: rtl/rename_unit.sv
module rename_unit
  import rename_pkg::*;
#(
  parameter int NUM_ARCH = DEF_NUM_ARCH,
  parameter int NUM_PHYS = DEF_NUM_PHYS,
  parameter int GROUP    = DEF_GROUP,
  parameter int NSRC     = DEF_NSRC,
  parameter int NRD      = DEF_NRD,
  parameter int DATA_W   = DEF_DATA_W,
  parameter int AREG_W   = $clog2(NUM_ARCH),
  parameter int TAG_W    = $clog2(NUM_PHYS)
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  ren_req,
  input  logic [GROUP-1:0]                      ren_dst_en,
  input  logic [GROUP-1:0][NSRC-1:0][AREG_W-1:0] ren_src_arch,
  input  logic [GROUP-1:0][AREG_W-1:0]          ren_dst_arch,
  output logic                                  ren_stall,
  output logic [GROUP-1:0][NSRC-1:0][TAG_W-1:0] ren_src_tag,
  output logic [GROUP-1:0][TAG_W-1:0]           ren_dst_tag,
  output logic [GROUP-1:0][TAG_W-1:0]           ren_old_tag,
  input  logic                                  rel_valid,
  input  logic [TAG_W-1:0]                      rel_tag,
  input  logic                                  wb_valid,
  input  logic [TAG_W-1:0]                      wb_tag,
  input  logic [DATA_W-1:0]                     wb_data,
  input  logic [NRD-1:0][TAG_W-1:0]             rd_tag,
  output logic [NRD-1:0][DATA_W-1:0]            rd_data
);
  localparam int IDX_W = idx_width(GROUP);

  logic [GROUP-1:0][IDX_W-1:0]            slot_idx;
  logic [GROUP-1:0]                       take, grant_ok, wr_en;
  logic [GROUP-1:0][TAG_W-1:0]            grant_tag, map_old;
  logic [GROUP-1:0][NSRC-1:0][TAG_W-1:0]  map_src;
  logic                                   commit;
  int                                     need, have;

  // Slot j takes the grant whose index counts the enabled older slots.
  always_comb begin
    need = 0;
    have = 0;
    for (int j = 0; j < GROUP; j++) begin
      slot_idx[j] = IDX_W'(need);
      if (ren_dst_en[j]) need = need + 1;
      if (grant_ok[j]) have = have + 1;
    end
  end

  assign ren_stall = ren_req && (need > have);
  assign commit    = ren_req && !ren_stall;

  always_comb begin
    for (int k = 0; k < GROUP; k++) begin
      take[k]  = commit && (k < need);
      wr_en[k] = commit && ren_dst_en[k];
    end
  end

  // Nearest older writer in the group overrides the table.
  always_comb begin
    for (int j = 0; j < GROUP; j++) begin
      ren_dst_tag[j] = grant_tag[slot_idx[j]];
      ren_old_tag[j] = map_old[j];
      for (int s = 0; s < NSRC; s++) ren_src_tag[j][s] = map_src[j][s];
      for (int i = 0; i < GROUP; i++) begin
        if (i < j && ren_dst_en[i]) begin
          if (ren_dst_arch[i] == ren_dst_arch[j]) ren_old_tag[j] = grant_tag[slot_idx[i]];
          for (int s = 0; s < NSRC; s++)
            if (ren_dst_arch[i] == ren_src_arch[j][s]) ren_src_tag[j][s] = grant_tag[slot_idx[i]];
        end
      end
    end
  end

  rename_free_pool #(
    .NUM_ARCH(NUM_ARCH), .NUM_PHYS(NUM_PHYS), .GROUP(GROUP), .TAG_W(TAG_W)
  ) u_pool (
    .clk(clk), .rst_n(rst_n), .take(take), .rel_valid(rel_valid), .rel_tag(rel_tag),
    .grant_ok(grant_ok), .grant_tag(grant_tag)
  );

  rename_map_table #(
    .NUM_ARCH(NUM_ARCH), .GROUP(GROUP), .NSRC(NSRC), .AREG_W(AREG_W), .TAG_W(TAG_W)
  ) u_map (
    .clk(clk), .rst_n(rst_n), .src_arch(ren_src_arch), .src_tag(map_src),
    .dst_arch(ren_dst_arch), .old_tag(map_old), .wr_en(wr_en), .wr_tag(ren_dst_tag)
  );

  rename_phys_file #(
    .NUM_PHYS(NUM_PHYS), .NRD(NRD), .TAG_W(TAG_W), .DATA_W(DATA_W)
  ) u_file (
    .clk(clk), .rst_n(rst_n), .wb_valid(wb_valid), .wb_tag(wb_tag), .wb_data(wb_data),
    .rd_tag(rd_tag), .rd_data(rd_data)
  );

  assert_stall_no_take_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ren_stall |-> (take == '0 && wr_en == '0));
  for (genvar j = 0; j < GROUP; j++) begin : g_chk
    assert_dst_tag_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en[j] |-> (int'(ren_dst_tag[j]) < NUM_PHYS));
  end
endmodule

// File: tb/rename_unit_tb_top.sv
module rename_unit_tb_top;
  localparam int NA = 32, NP = 80, G = 2, NS = 2, NR = 4, DW = 32, AW = 5, TW = 7;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ren_req = 1'b0;
  logic [G-1:0] ren_dst_en = '0;
  logic [G-1:0][NS-1:0][AW-1:0] ren_src_arch = '0;
  logic [G-1:0][AW-1:0] ren_dst_arch = '0;
  logic ren_stall;
  logic [G-1:0][NS-1:0][TW-1:0] ren_src_tag;
  logic [G-1:0][TW-1:0] ren_dst_tag, ren_old_tag;
  logic rel_valid = 1'b0;
  logic [TW-1:0] rel_tag = '0;
  logic wb_valid = 1'b0;
  logic [TW-1:0] wb_tag = '0;
  logic [DW-1:0] wb_data = '0;
  logic [NR-1:0][TW-1:0] rd_tag = '0;
  logic [NR-1:0][DW-1:0] rd_data;

  always #4 clk = ~clk;

  rename_unit dut_i (.*);

  int total = 0, bad = 0;
  int mmap [NA];
  bit mfree [NP];
  bit mvalid [NP];
  logic [DW-1:0] mdata [NP];
  int relq [$];
  bit done = 1'b0;

  task automatic check(input string req, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < NA; i++) mmap[i] = i;
    for (int t = 0; t < NP; t++) begin mfree[t] = (t >= NA); mvalid[t] = 1'b0; end
    relq.delete();
  endtask

  // One cycle: inputs already driven after a falling edge.
  task automatic cycle(input bit do_cmp);
    int g[G];
    int nfree, need, idx;
    int dtag[G];
    int otag[G];
    int st;
    bit stall;
    nfree = 0;
    for (int t = 0; t < NP && nfree < G; t++) if (mfree[t]) begin g[nfree] = t; nfree++; end
    need = 0;
    for (int j = 0; j < G; j++) if (ren_dst_en[j]) need++;
    stall = ren_req && (need > nfree);
    idx = 0;
    for (int j = 0; j < G; j++) begin
      dtag[j] = (idx < nfree) ? g[idx] : 0;
      if (ren_dst_en[j]) idx++;
    end
    #3;
    if (do_cmp) begin
      check("R5 stall", ren_stall, stall);
      if (need <= nfree) begin
        for (int j = 0; j < G; j++) begin
          otag[j] = mmap[ren_dst_arch[j]];
          for (int i = 0; i < j; i++)
            if (ren_dst_en[i] && ren_dst_arch[i] == ren_dst_arch[j]) otag[j] = dtag[i];
          check("R7 old tag", ren_old_tag[j], otag[j]);
          if (ren_dst_en[j]) check("R3/R4 new tag", ren_dst_tag[j], dtag[j]);
          for (int s = 0; s < NS; s++) begin
            st = mmap[ren_src_arch[j][s]];
            for (int i = 0; i < j; i++)
              if (ren_dst_en[i] && ren_dst_arch[i] == ren_src_arch[j][s]) st = dtag[i];
            check("R2/R6 src tag", ren_src_tag[j][s], st);
          end
        end
      end
      for (int r = 0; r < NR; r++) begin
        if (int'(rd_tag[r]) >= NP) check("R10 read unused tag", rd_data[r], 0);
        else if (mvalid[rd_tag[r]]) check("R9 read data", rd_data[r], mdata[rd_tag[r]]);
      end
    end
    @(posedge clk);
    if (ren_req && !stall) begin
      for (int j = 0; j < G; j++) if (ren_dst_en[j]) begin
        relq.push_back(otag_or_map(j, dtag));
        mmap[ren_dst_arch[j]] = dtag[j];
        mfree[dtag[j]] = 1'b0;
      end
    end
    if (rel_valid && int'(rel_tag) < NP) mfree[rel_tag] = 1'b1;
    if (wb_valid && int'(wb_tag) < NP) begin mdata[wb_tag] = wb_data; mvalid[wb_tag] = 1'b1; end
    @(negedge clk);
  endtask

  // Old tag of slot j, using the map before the group's own writes.
  function automatic int otag_or_map(input int j, input int dtag[G]);
    int o;
    o = mmap[ren_dst_arch[j]];
    for (int i = 0; i < j; i++)
      if (ren_dst_en[i] && ren_dst_arch[i] == ren_dst_arch[j]) o = dtag[i];
    return o;
  endfunction

  task automatic rand_inputs(input bit allow_rel);
    ren_req = ($urandom_range(0, 9) != 0);
    for (int j = 0; j < G; j++) begin
      ren_dst_en[j] = $urandom_range(0, 3) != 0;
      ren_dst_arch[j] = AW'($urandom_range(0, 7));
      for (int s = 0; s < NS; s++) ren_src_arch[j][s] = AW'($urandom_range(0, 7));
    end
    rel_valid = 1'b0;
    if (allow_rel && relq.size() > 0 && $urandom_range(0, 2) != 0) begin
      rel_valid = 1'b1;
      rel_tag = TW'(relq.pop_front());
    end else if ($urandom_range(0, 7) == 0) begin
      rel_valid = 1'b1;
      rel_tag = TW'($urandom_range(NP, 127));
    end
    wb_valid = $urandom_range(0, 1) != 0;
    wb_tag = TW'($urandom_range(0, 127));
    wb_data = $urandom();
    for (int r = 0; r < NR; r++) rd_tag[r] = TW'($urandom_range(0, 127));
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset mapping read through the source ports.
    for (int c = 0; c < NA / (G * NS); c++) begin
      for (int j = 0; j < G; j++)
        for (int s = 0; s < NS; s++) ren_src_arch[j][s] = AW'(c * G * NS + j * NS + s);
      #3;
      for (int j = 0; j < G; j++)
        for (int s = 0; s < NS; s++)
          check("R1 reset map", ren_src_tag[j][s], c * G * NS + j * NS + s);
      @(negedge clk);
    end
    // R1/R3: first allocations are the lowest spare tags, slot order.
    ren_req = 1'b1; ren_dst_en = '1;
    ren_dst_arch[0] = 5'd3; ren_dst_arch[1] = 5'd3;
    ren_src_arch[1][0] = 5'd3; ren_src_arch[1][1] = 5'd9;
    #3;
    check("R1 first tag", ren_dst_tag[0], NA);
    check("R3 second tag", ren_dst_tag[1], NA + 1);
    check("R6 bypass", ren_src_tag[1][0], NA);
    check("R7 old tag bypass", ren_old_tag[1], NA);
    @(negedge clk);
    ren_req = 1'b0;
    ren_src_arch[0][0] = 5'd3;
    #3;
    check("R7 younger wins", ren_src_tag[0][0], NA + 1);
    @(negedge clk);
    rst_n = 1'b0; model_reset();
    @(negedge clk); rst_n = 1'b1;
    // R10: write to unused tag, read back zero.
    wb_valid = 1'b1; wb_tag = 7'd100; wb_data = 32'hdead_beef; rd_tag[0] = 7'd100;
    cycle(1'b1);
    wb_valid = 1'b0;
    cycle(1'b1);
    // Drain pool without release (R5 stall, R8 bad release ignored).
    for (int c = 0; c < 60; c++) begin rand_inputs(1'b0); cycle(1'b1); end
    // Mixed traffic with releases.
    for (int c = 0; c < 3000; c++) begin rand_inputs(1'b1); cycle(1'b1); end
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule